// File: doc/BRIEF.md
# Single-Wire Parity Chunk PHY

This block moves one chunk of data across a single open-drain wire that is pulled high by a resistor. The link is half duplex. A pulse on `startTx` sends a chunk. A pulse on `startRx` receives one. The user picks a chunk width of 7 or 8 data bits with `wideSel`. A single `done` pulse closes every chunk.

A sent chunk has three parts:
- A low sync pulse one bit time long.
- A short high mark, whose rising edge tells the partner where the data begins.
- The data bits, most significant bit first, followed by an even-parity bit.

After the parity bit the sender keeps the wire driven low. This makes the rising edge of the next sync visible.

The receiver waits a bounded time for the wire to fall, then waits for it to rise. It then samples every bit near its middle. A parity mismatch does not stop reception; it only raises `parityErr` for that chunk. The bit time is chosen from a small set of microsecond values and the clock rate, both given as parameters. Sequencing of chunks into transactions, turnaround and acknowledge are left to the layer above.

Top module: `wire_chunk_phy`

## Requirements
- R1: After reset, the wire is released (`pinOe`=0), and `done`, `parityErr` and `rxData` are 0.
- R2: In the clock edge where `startTx` is taken, the block starts driving the wire low. It keeps it low for exactly BIT cycles, then drives it high for MARK_CYCLES cycles. BIT = CLK_MHZ × {4,6,12,24,36,48}[SPEED_SEL]; for example, SPEED_SEL=0 gives 4 µs.
- R3: Data bits follow the mark, most significant first, each driven for BIT cycles. With `wideSel`=1 all 8 bits of `txData` are sent. With `wideSel`=0 only `txData[6:0]` are sent, and `txData[7]` has no effect on the wire.
- R4: After the last data bit, one parity bit is sent for BIT cycles. It equals the XOR of the sent data bits, so data plus parity hold an even number of ones.
- R5: In the cycle the parity bit ends, `done` pulses for one cycle and the wire is driven low (`pinOe`=1, `pinOut`=0). The wire stays low until the next start.
- R6: A received chunk yields its data bits right-aligned in `rxData`, first received bit as MSB. In narrow mode bit 7 is 0. Each bit is sampled MARK_CYCLES + BIT/2 cycles after the detected sync rise, plus whole bit times.
- R7: A chunk whose parity bit does not match its data still completes with `done`, with the received data in `rxData` and `parityErr`=1. A matching chunk gives `parityErr`=0.
- R8: If the wire does not fall within SEEK_BITS×BIT cycles of `startRx`, reception proceeds as if the sync had risen at that moment. On an idle high wire, `done` comes exactly SEEK + MARK_CYCLES + BIT/2 + N×BIT cycles after the start edge, with all data ones.
- R9: Start strobes arriving while a chunk is in progress are ignored. If `startTx` and `startRx` arrive together, the send wins.
- R10: During reception the block never drives the wire (`pinOe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startTx | input | 1 | Strobe: send one chunk |
| startRx | input | 1 | Strobe: receive one chunk |
| wideSel | input | 1 | 1 = 8-bit chunk, 0 = 7-bit chunk |
| txData | input | MAX_BITS | Word to send, right-aligned |
| rxData | output | MAX_BITS | Last received word, right-aligned |
| parityErr | output | 1 | Parity mismatch on the last received chunk |
| done | output | 1 | One-cycle pulse at the end of a chunk |
| pinIn | input | 1 | Wire level as seen at the pad |
| pinOe | output | 1 | Pad output enable (0 = released) |
| pinOut | output | 1 | Pad output level when enabled |

## Verification
The bench checks the following corner cases, each against an expected result computed in the bench:
- **Narrow chunks with bit 7 set.** A block that leaked the unused bit would shift a wrong value onto the wire.
- **All-zero and all-one words.** These expose a parity bit of the wrong sense, and a missing mark when the first data bit is low.
- **Corrupted parity.** A receiver that aborted on the error would never raise `done`.
- **Idle, disconnected wire.** This must end at one exact cycle with all ones and the width-dependent parity flag; a receiver without the bound would hang.
- **Start strobes during a chunk, and both strobes together.** A design that re-armed would cut the waveform short or start receiving instead of sending.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TX_SYNC,
    PH_TX_MARK,
    PH_TX_BITS,
    PH_RX_SEEK,
    PH_RX_WAIT_HI,
    PH_RX_BITS
  } phaseT;

  typedef enum logic [1:0] {
    DRV_RELEASE,
    DRV_LOW,
    DRV_HIGH,
    DRV_DATA
  } driveT;

  // strobes from control to datapath
  typedef struct packed {
    logic  loadTx;
    logic  armRx;
    logic  advance;
    logic  capture;
    driveT drive;
  } dpCtrlT;

  // bit time in microseconds for each speed selection
  function automatic int bitMicros(input int sel);
    case (sel)
      0:       return 4;
      1:       return 6;
      2:       return 12;
      3:       return 24;
      4:       return 36;
      default: return 48;
    endcase
  endfunction

endpackage

// File: rtl/wcp_datapath.sv
module wcp_datapath
  import wcp_pkg::*;
#(
  parameter int MAX_BITS    = 8,
  parameter int NARROW_BITS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrlT              ctrl,
  input  logic                wideSel,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                pinIn,
  output logic                pinSync,
  output logic                lastBit,
  output logic                pinOe,
  output logic                pinOut,
  output logic [MAX_BITS-1:0] rxData,
  output logic                parityErr
);

  localparam int FW      = MAX_BITS + 1;
  localparam int CW      = $clog2(FW + 1);
  localparam int SHIFT_N = MAX_BITS - NARROW_BITS;
  localparam logic [MAX_BITS-1:0] NARROW_MASK = MAX_BITS'((1 << NARROW_BITS) - 1);

  logic [1:0]          syncQ;
  logic [FW-1:0]       frameQ;
  logic [CW-1:0]       bitsLeft;
  logic [MAX_BITS-1:0] rxDataQ;
  logic                parErrQ;

  logic [MAX_BITS-1:0] maskedData;
  logic                txParity;
  logic [FW-1:0]       txFrame;
  logic [CW-1:0]       loadCount;
  logic [FW-1:0]       shiftIn;

  // two-flop synchronizer; idle wire reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], pinIn};
  end
  assign pinSync = syncQ[1];

  // transmit frame: data left-aligned, parity bit last
  always_comb begin
    maskedData = wideSel ? txData : (txData & NARROW_MASK);
    txParity   = ^maskedData;
    if (wideSel) txFrame = {maskedData, txParity};
    else         txFrame = {maskedData, txParity} << SHIFT_N;
    loadCount  = wideSel ? CW'(MAX_BITS + 1) : CW'(NARROW_BITS + 1);
    shiftIn    = {frameQ[FW-2:0], pinSync};
  end

  assign lastBit = (bitsLeft == CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ   <= '0;
      bitsLeft <= '0;
      rxDataQ  <= '0;
      parErrQ  <= 1'b0;
    end else if (ctrl.loadTx) begin
      frameQ   <= txFrame;
      bitsLeft <= loadCount;
    end else if (ctrl.armRx) begin
      frameQ   <= '0;
      bitsLeft <= loadCount;
    end else if (ctrl.advance) begin
      frameQ   <= {frameQ[FW-2:0], 1'b0};
      bitsLeft <= bitsLeft - CW'(1);
    end else if (ctrl.capture) begin
      frameQ   <= shiftIn;
      bitsLeft <= bitsLeft - CW'(1);
      if (lastBit) begin
        // unused top bits stay zero, so the whole frame gives word and parity
        rxDataQ <= shiftIn[FW-1:1];
        parErrQ <= ^shiftIn;
      end
    end
  end

  always_comb begin
    case (ctrl.drive)
      DRV_LOW:  begin pinOe = 1'b1; pinOut = 1'b0;          end
      DRV_HIGH: begin pinOe = 1'b1; pinOut = 1'b1;          end
      DRV_DATA: begin pinOe = 1'b1; pinOut = frameQ[FW-1];  end
      default:  begin pinOe = 1'b0; pinOut = 1'b0;          end
    endcase
  end

  assign rxData    = rxDataQ;
  assign parityErr = parErrQ;

  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadTx, ctrl.armRx, ctrl.advance, ctrl.capture}));

  assert_count_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance || ctrl.capture) |-> (bitsLeft != '0));

  assert_rx_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |-> !pinOe);

endmodule

// File: rtl/wcp_control.sv
module wcp_control
  import wcp_pkg::*;
#(
  parameter int BIT_CYCLES  = 600,
  parameter int MARK_CYCLES = 2,
  parameter int SEEK_BITS   = 5
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startTx,
  input  logic   startRx,
  input  logic   pinSync,
  input  logic   lastBit,
  output dpCtrlT ctrl,
  output logic   done
);

  localparam int SEEK_CYCLES  = SEEK_BITS * BIT_CYCLES;
  localparam int FIRST_CYCLES = MARK_CYCLES + BIT_CYCLES / 2;
  localparam int TW           = $clog2(SEEK_CYCLES + 1);

  phaseT         phaseQ, phaseD;
  logic [TW-1:0] timerQ, timerD;
  logic          holdLowQ, holdLowD;
  logic          doneQ, doneD;
  logic          timeUp;

  assign timeUp = (timerQ == '0);

  always_comb begin
    phaseD     = phaseQ;
    timerD     = timeUp ? timerQ : timerQ - TW'(1);
    holdLowD   = holdLowQ;
    doneD      = 1'b0;
    ctrl       = '0;
    ctrl.drive = DRV_RELEASE;
    case (phaseQ)
      PH_IDLE: begin
        ctrl.drive = holdLowQ ? DRV_LOW : DRV_RELEASE;
        if (startTx) begin
          ctrl.loadTx = 1'b1;
          phaseD      = PH_TX_SYNC;
          timerD      = TW'(BIT_CYCLES - 1);
          holdLowD    = 1'b0;
        end else if (startRx) begin
          ctrl.armRx  = 1'b1;
          phaseD      = PH_RX_SEEK;
          timerD      = TW'(SEEK_CYCLES - 1);
          holdLowD    = 1'b0;
        end
      end
      PH_TX_SYNC: begin
        ctrl.drive = DRV_LOW;
        if (timeUp) begin
          phaseD = PH_TX_MARK;
          timerD = TW'(MARK_CYCLES - 1);
        end
      end
      PH_TX_MARK: begin
        ctrl.drive = DRV_HIGH;
        if (timeUp) begin
          phaseD = PH_TX_BITS;
          timerD = TW'(BIT_CYCLES - 1);
        end
      end
      PH_TX_BITS: begin
        ctrl.drive = DRV_DATA;
        if (timeUp) begin
          ctrl.advance = 1'b1;
          if (lastBit) begin
            phaseD   = PH_IDLE;
            doneD    = 1'b1;
            holdLowD = 1'b1;
          end else begin
            timerD = TW'(BIT_CYCLES - 1);
          end
        end
      end
      PH_RX_SEEK: begin
        if (!pinSync) begin
          phaseD = PH_RX_WAIT_HI;
        end else if (timeUp) begin
          phaseD = PH_RX_BITS;
          timerD = TW'(FIRST_CYCLES - 1);
        end
      end
      PH_RX_WAIT_HI: begin
        if (pinSync) begin
          phaseD = PH_RX_BITS;
          timerD = TW'(FIRST_CYCLES - 1);
        end
      end
      PH_RX_BITS: begin
        if (timeUp) begin
          ctrl.capture = 1'b1;
          if (lastBit) begin
            phaseD = PH_IDLE;
            doneD  = 1'b1;
          end else begin
            timerD = TW'(BIT_CYCLES - 1);
          end
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      timerQ   <= '0;
      holdLowQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      phaseQ   <= phaseD;
      timerQ   <= timerD;
      holdLowQ <= holdLowD;
      doneQ    <= doneD;
    end
  end

  assign done = doneQ;

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != PH_IDLE) |-> !(ctrl.loadTx || ctrl.armRx));

endmodule

// File: rtl/wire_chunk_phy.sv
module wire_chunk_phy
  import wcp_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int SPEED_SEL   = 1,
  parameter int MAX_BITS    = 8,
  parameter int NARROW_BITS = 7,
  parameter int MARK_CYCLES = 2,
  parameter int SEEK_BITS   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startTx,
  input  logic                startRx,
  input  logic                wideSel,
  input  logic [MAX_BITS-1:0] txData,
  output logic [MAX_BITS-1:0] rxData,
  output logic                parityErr,
  output logic                done,
  input  logic                pinIn,
  output logic                pinOe,
  output logic                pinOut
);

  localparam int BIT_CYCLES = CLK_MHZ * bitMicros(SPEED_SEL);

  dpCtrlT ctrl;
  logic   pinSync;
  logic   lastBit;

  wcp_control #(
    .BIT_CYCLES (BIT_CYCLES),
    .MARK_CYCLES(MARK_CYCLES),
    .SEEK_BITS  (SEEK_BITS)
  ) uControl (
    .clk    (clk),
    .rstN   (rstN),
    .startTx(startTx),
    .startRx(startRx),
    .pinSync(pinSync),
    .lastBit(lastBit),
    .ctrl   (ctrl),
    .done   (done)
  );

  wcp_datapath #(
    .MAX_BITS   (MAX_BITS),
    .NARROW_BITS(NARROW_BITS)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wideSel  (wideSel),
    .txData   (txData),
    .pinIn    (pinIn),
    .pinSync  (pinSync),
    .lastBit  (lastBit),
    .pinOe    (pinOe),
    .pinOut   (pinOut),
    .rxData   (rxData),
    .parityErr(parityErr)
  );

  // a driven wire at the end of a chunk is always low
  assert_low_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && pinOe) |-> !pinOut);

endmodule

// File: tb/tb_wire_chunk_phy.sv
module tb_wire_chunk_phy;

  localparam int CLK_MHZ = 4;
  localparam int SPEED   = 0;
  localparam int BIT     = 16;   // 4 us at 4 MHz
  localparam int MARK    = 2;
  localparam int SEEK    = 5 * BIT;
  localparam int FIRST   = MARK + BIT / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startTx = 1'b0;
  logic       startRx = 1'b0;
  logic       wideSel = 1'b1;
  logic [7:0] txData = '0;
  logic [7:0] rxData;
  logic       parityErr, done, pinIn, pinOe, pinOut;
  logic       lineQ = 1'b1;

  int nChecks = 0;
  int nFails  = 0;

  assign pinIn = lineQ;

  wire_chunk_phy #(.CLK_MHZ(CLK_MHZ), .SPEED_SEL(SPEED), .MARK_CYCLES(MARK)) dut (
    .clk(clk), .rstN(rstN), .startTx(startTx), .startRx(startRx), .wideSel(wideSel),
    .txData(txData), .rxData(rxData), .parityErr(parityErr), .done(done),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int chunkLen(input logic wide);
    return wide ? 8 : 7;
  endfunction

  function automatic logic evenPar(input logic [7:0] d, input logic wide);
    return wide ? ^d : ^d[6:0];
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // send one chunk and check every segment of the waveform (R2..R5, R9)
  task automatic runTx(input logic [7:0] d, input logic wide, input logic alsoRx, input logic poke);
    int n, endT;
    logic expBit;
    n = chunkLen(wide);
    endT = BIT + MARK + (n + 1) * BIT;
    @(negedge clk);
    txData = d; wideSel = wide; startTx = 1'b1; startRx = alsoRx;
    step();
    startTx = 1'b0; startRx = 1'b0;
    for (int t = 0; t <= endT; t++) begin
      if (poke) begin
        startRx = (t == 3 * BIT);
        startTx = (t == 5 * BIT);
      end
      if (t == BIT / 2)        check("R2 sync low", {pinOe, pinOut}, 2'b10);
      if (t == BIT - 1)        check("R2 sync length", {pinOe, pinOut}, 2'b10);
      if (t == BIT)            check("R2 mark high", {pinOe, pinOut}, 2'b11);
      if (t == BIT + MARK - 1) check("R2 mark length", {pinOe, pinOut}, 2'b11);
      for (int i = 0; i <= n; i++) begin
        if (t == BIT + MARK + i * BIT + BIT / 2) begin
          expBit = (i < n) ? d[n - 1 - i] : evenPar(d, wide);
          if (i < n) check("R3 data bit", {pinOe, pinOut}, {1'b1, expBit});
          else       check("R4 parity bit", {pinOe, pinOut}, {1'b1, expBit});
        end
      end
      if (t < endT && done) check("R5 done early", 1, 0);
      if (t == endT) begin
        check("R5 done pulse", done, 1'b1);
        check("R5 low at end", {pinOe, pinOut}, 2'b10);
      end
      if (t < endT) step();
    end
    startTx = 1'b0; startRx = 1'b0;
    step();
    check("R5 done one cycle", done, 1'b0);
    repeat (BIT) step();
    check("R5 line held low", {pinOe, pinOut}, 2'b10);
  endtask

  // receive one chunk from a bench partner (R6, R7, R10), or from an idle wire (R8)
  task automatic runRx(input logic [7:0] d, input logic wide, input logic flip,
                       input int gap, input logic silent);
    int n, t, doneT, segT;
    logic drove, parBit;
    logic [7:0] expData;
    n = chunkLen(wide);
    drove = 1'b0;
    doneT = -1;
    parBit = evenPar(d, wide) ^ flip;
    @(negedge clk);
    wideSel = wide; startRx = 1'b1;
    step();
    startRx = 1'b0;
    t = 0;
    while (doneT < 0 && t < SEEK + 20 * BIT) begin
      if (silent) lineQ = 1'b1;
      else begin
        segT = t - gap;
        if (segT < 0)                lineQ = 1'b1;
        else if (segT < BIT)         lineQ = 1'b0;
        else if (segT < BIT + MARK)  lineQ = 1'b1;
        else begin
          int idx;
          idx = (segT - BIT - MARK) / BIT;
          if (idx < n)       lineQ = d[n - 1 - idx];
          else if (idx == n) lineQ = parBit;
          else               lineQ = 1'b0;
        end
      end
      if (pinOe) drove = 1'b1;
      if (done) doneT = t;
      else begin
        step();
        t++;
      end
    end
    check("R10 released during rx", drove, 1'b0);
    check("R6 rx done seen", (doneT >= 0), 1'b1);
    if (silent) begin
      check("R8 timeout done cycle", doneT, SEEK + FIRST + n * BIT);
      check("R8 all ones", rxData, wide ? 8'hFF : 8'h7F);
      check("R8 parity flag", parityErr, wide ? 1'b1 : 1'b0);
    end else begin
      expData = wide ? d : {1'b0, d[6:0]};
      check("R6 rx data", rxData, expData);
      check("R7 parity flag", parityErr, flip);
    end
    step();
    lineQ = 1'b1;
    repeat (4) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    check("R1 released", pinOe, 1'b0);
    check("R1 done low", done, 1'b0);
    check("R1 rxData zero", rxData, 8'h00);
    check("R1 parity zero", parityErr, 1'b0);
    rstN = 1'b1;
    repeat (3) step();
    check("R1 still released", pinOe, 1'b0);

    // directed sends
    runTx(8'h00, 1'b1, 1'b0, 1'b0);
    runTx(8'hFF, 1'b1, 1'b0, 1'b0);
    runTx(8'hFF, 1'b0, 1'b0, 1'b0);   // R3: bit 7 ignored in narrow mode
    runTx(8'h80, 1'b0, 1'b0, 1'b0);
    runTx(8'hA5, 1'b1, 1'b1, 1'b0);   // R9: both strobes, send wins
    runTx(8'h3C, 1'b1, 1'b0, 1'b1);   // R9: strobes during chunk ignored

    // directed receives
    runRx(8'h00, 1'b1, 1'b0, 4, 1'b0);
    runRx(8'hFF, 1'b1, 1'b1, 10, 1'b0);
    runRx(8'hD3, 1'b0, 1'b0, 0, 1'b0);
    runRx(8'h5A, 1'b0, 1'b1, 2 * BIT, 1'b0);
    runRx(8'h00, 1'b1, 1'b0, 0, 1'b1);  // R8 idle wire, 8 bits
    runRx(8'h00, 1'b0, 1'b0, 0, 1'b1);  // R8 idle wire, 7 bits

    // random mix
    for (int k = 0; k < 14; k++) begin
      logic [7:0] rd;
      logic rw, rf;
      int rg;
      rd = 8'($urandom);
      rw = 1'($urandom);
      rf = 1'($urandom);
      rg = int'($urandom % (3 * BIT));
      runTx(rd, rw, 1'b0, 1'b0);
      runRx(8'($urandom), rw, rf, rg, 1'b0);
    end

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

endmodule